// File: doc/BRIEF.md
# DMA Channel Control/Status and Interrupt Summary

This block keeps one 32-bit control/status word per channel of a multi-channel DMA controller. It also forms the interrupt summary across the channels. Software reaches it through a simple word-wide memory-mapped slave port. Each word has two parts:

- an upper control part, which software replaces on every write;
- a lower status part, whose sticky flags the channel engines set through one-cycle event pulses and software clears by writing 1.

Both parts change within the same write. The block drives these outputs:

- `run_o`, a run level for each channel;
- `fetch_o`, a one-cycle pulse that starts a descriptor fetch when a channel is started in descriptor mode;
- `irq_o`, one combined interrupt line.

A summary word at offset 0xF0 shows which channels hold an active interrupt. Three flags take part in the interrupt only when their own enable bit is set: channel stopped, end of receive and request after stop. The descriptor-start and transfer-end flags take part with no enable. The bus-error flag is stored but never raises the interrupt.

The request-pending bit is not stored. A read returns it from the live request level of the channel. Data movement, descriptor fetching and request routing sit outside the block and reach it only through the event and level inputs.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every channel word reads 0x00000008, with the stopped flag (bit 3) set and run (bit 31) clear. All `run_o` and `fetch_o` bits are 0, `irq_o` is 0 and the summary reads 0.
- R2: A write clears status bit 0 (bus error), bit 1 (descriptor start), bit 2 (transfer end) or bit 9 (end of receive) for each 1 written there. Bit 4 (request after stop) and the other status bits keep their value.
- R3: A write loads control bits 23, 26, 27, 28, 29, 30 and 31 from the written value. Bits 22, 24 and 25 are actions and always read 0.
- R4: A write with bit 31 set clears the stopped flag and raises `run_o`. If bit 30 (no descriptor fetch) is clear in that write, `fetch_o` pulses for exactly one cycle; if bit 30 is set, `fetch_o` stays 0.
- R5: A write with both bit 31 and bit 22 (mask-run) clear sets the stopped flag. A write with only bit 22 set leaves the stopped flag unchanged.
- R6: Writing bit 24 clears compare status (bit 10), and writing bit 25 sets it. When both bits are written, the flag ends up set.
- R7: An event pulse sets its flag in the cycle after it is sampled. If an event and a write-1-clear of the same flag land in one cycle, the flag stays set. The engine-stopped event sets bit 3 and clears bit 31.
- R8: Bit 3 raises a channel's interrupt only with bit 29 set. Bit 9 raises it only with bit 28 set, and bit 4 only with bit 23 set. Bits 1 and 2 raise it unconditionally, and bit 0 never does.
- R9: The word at 0xF0 has bit c set when channel c has an active interrupt. `irq_o` is the OR of these bits.
- R10: Bit 8 of a channel read equals that channel's `dreq_i` level at the sampling edge.
- R11: An access with `size_i` other than 2 (word) or with `addr_i[1:0]` nonzero is answered with `err_o` and `ack_o` together. It changes no state and returns read data 0.
- R12: Every access is acknowledged with `ack_o` one cycle after `req_i` is sampled. Channel c sits at byte offset 4*c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access width: 0 byte, 1 half, 2 word |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access response, one cycle after request |
| err_o | output | 1 | Error response, valid with ack_o |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ev_buserr_i | input | NUM_CH | Bus-error event pulse per channel |
| ev_start_i | input | NUM_CH | Descriptor-start event pulse per channel |
| ev_end_i | input | NUM_CH | Transfer-end event pulse per channel |
| ev_stop_i | input | NUM_CH | Engine-stopped event pulse per channel |
| ev_ras_i | input | NUM_CH | Request-after-stop event pulse per channel |
| ev_eor_i | input | NUM_CH | End-of-receive event pulse per channel |
| dreq_i | input | NUM_CH | Live request level per channel |
| run_o | output | NUM_CH | Run command per channel |
| fetch_o | output | NUM_CH | One-cycle descriptor fetch start per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
A write or an event sampled at edge k updates the channel word at edge k. From that edge on, `run_o` and `irq_o` follow combinationally, and `fetch_o` is high from edge k to edge k+1. A read sampled at edge k returns, with `ack_o` from edge k, the state before that edge. The bench drives every stimulus on a falling edge and returns from each access task on the next falling edge. It checks `run_o`, `fetch_o` and `irq_o` there, and once more one cycle later for the end of the fetch pulse. The scoreboard queues the expected read data and error flag for each access and pops them on the falling edge where `ack_o` is seen.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int B_BUSERR  = 0;
  localparam int B_START   = 1;
  localparam int B_END     = 2;
  localparam int B_STOP    = 3;
  localparam int B_RAS     = 4;
  localparam int B_REQPEND = 8;
  localparam int B_EOR     = 9;
  localparam int B_CMP     = 10;
  localparam int B_MASKRUN = 22;
  localparam int B_RASIE   = 23;
  localparam int B_CLRCMP  = 24;
  localparam int B_SETCMP  = 25;
  localparam int B_EORSTOP = 26;
  localparam int B_EORJMP  = 27;
  localparam int B_EORIE   = 28;
  localparam int B_STOPIE  = 29;
  localparam int B_NOFETCH = 30;
  localparam int B_RUN     = 31;

  localparam logic [31:0] STS_KEEP = 32'h0000_061F;
  localparam logic [31:0] W1C_MASK = 32'h0000_0207;
  localparam logic [31:0] CTL_LOAD = 32'hFC80_0000;
  localparam logic [31:0] RST_VAL  = 32'h0000_0008;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  function automatic logic chan_irq(input logic [31:0] w);
    return (w[B_STOP] & w[B_STOPIE]) | (w[B_EOR] & w[B_EORIE]) |
           (w[B_RAS] & w[B_RASIE]) | w[B_START] | w[B_END];
  endfunction
endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        ev_buserr_i,
  input  logic        ev_start_i,
  input  logic        ev_end_i,
  input  logic        ev_stop_i,
  input  logic        ev_ras_i,
  input  logic        ev_eor_i,
  output logic [31:0] csr_o,
  output logic        irq_o,
  output logic        run_o,
  output logic        fetch_o
);
  logic [31:0] csr_q, csr_d;
  logic        fetch_q, fetch_d;

  always_comb begin
    csr_d = csr_q;
    if (wr_i) begin
      csr_d = (csr_q & STS_KEEP & ~(wdata_i & W1C_MASK)) | (wdata_i & CTL_LOAD);
      if (wdata_i[B_RUN])           csr_d[B_STOP] = 1'b0;
      else if (!wdata_i[B_MASKRUN]) csr_d[B_STOP] = 1'b1;
      if (wdata_i[B_CLRCMP]) csr_d[B_CMP] = 1'b0;
      if (wdata_i[B_SETCMP]) csr_d[B_CMP] = 1'b1;
    end
    // events win over a same-cycle write
    if (ev_buserr_i) csr_d[B_BUSERR] = 1'b1;
    if (ev_start_i)  csr_d[B_START]  = 1'b1;
    if (ev_end_i)    csr_d[B_END]    = 1'b1;
    if (ev_ras_i)    csr_d[B_RAS]    = 1'b1;
    if (ev_eor_i)    csr_d[B_EOR]    = 1'b1;
    if (ev_stop_i) begin
      csr_d[B_STOP] = 1'b1;
      csr_d[B_RUN]  = 1'b0;
    end
  end

  assign fetch_d = wr_i & wdata_i[B_RUN] & ~wdata_i[B_NOFETCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q   <= RST_VAL;
      fetch_q <= 1'b0;
    end else begin
      csr_q   <= csr_d;
      fetch_q <= fetch_d;
    end
  end

  assign csr_o   = csr_q;
  assign irq_o   = chan_irq(csr_q);
  assign run_o   = csr_q[B_RUN];
  assign fetch_o = fetch_q;

  assert_run_clears_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> !csr_q[B_STOP]);
  assert_fetch_from_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> $past(wr_i));
  assert_start_event_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_start_i |=> csr_q[B_START]);
  assert_stop_event_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop_i |=> (csr_q[B_STOP] && !run_o));
  assert_setcmp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_SETCMP]) |=> csr_q[B_CMP]);
endmodule

// File: rtl/dma_csr_bus.sv
module dma_csr_bus
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SUM_OFS = 'hF0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [1:0]             size_i,
  input  logic [NUM_CH-1:0][31:0] csr_i,
  input  logic [NUM_CH-1:0]      dreq_i,
  input  logic [NUM_CH-1:0]      irq_vec_i,
  output logic [NUM_CH-1:0]      wr_o,
  output logic                   ack_o,
  output logic                   err_o,
  output logic [31:0]            rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic              ok;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       rd_val;
  logic              ack_q, err_q;
  logic [31:0]       rdata_q;

  assign ok  = (size_i == SIZE_WORD) && (addr_i[1:0] == 2'b00);
  assign idx = addr_i[ADDR_W-1:2];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign wr_o[c] = req_i & we_i & ok & (idx == IDX_W'(c));
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == SUM_OFS) rd_val = 32'(irq_vec_i);
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx == IDX_W'(c)) begin
        rd_val = csr_i[c];
        rd_val[B_REQPEND] = dreq_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i;
      err_q   <= req_i & ~ok;
      rdata_q <= (req_i && !we_i && ok) ? rd_val : 32'h0;
    end
  end

  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  assert_ack_next_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  assert_err_acked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ack_o && rdata_o == 32'h0));
  assert_bad_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != SIZE_WORD) |-> (wr_o == '0));
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] ev_buserr_i,
  input  logic [NUM_CH-1:0] ev_start_i,
  input  logic [NUM_CH-1:0] ev_end_i,
  input  logic [NUM_CH-1:0] ev_stop_i,
  input  logic [NUM_CH-1:0] ev_ras_i,
  input  logic [NUM_CH-1:0] ev_eor_i,
  input  logic [NUM_CH-1:0] dreq_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] fetch_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0][31:0] csr;
  logic [NUM_CH-1:0]       irq_vec;
  logic [NUM_CH-1:0]       wr;

  dma_csr_bus #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i,
    .csr_i(csr), .dreq_i, .irq_vec_i(irq_vec),
    .wr_o(wr), .ack_o, .err_o, .rdata_o
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_csr_chan u_ch (
      .clk_i, .rst_ni,
      .wr_i(wr[c]), .wdata_i,
      .ev_buserr_i(ev_buserr_i[c]), .ev_start_i(ev_start_i[c]),
      .ev_end_i(ev_end_i[c]), .ev_stop_i(ev_stop_i[c]),
      .ev_ras_i(ev_ras_i[c]), .ev_eor_i(ev_eor_i[c]),
      .csr_o(csr[c]), .irq_o(irq_vec[c]),
      .run_o(run_o[c]), .fetch_o(fetch_o[c])
    );
  end

  assign irq_o = |irq_vec;

  assert_end_unconditional_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_end_i != '0) |=> irq_o);
  assert_fetch_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fetch_o));
endmodule

// File: tb/dma_chan_csr_test.sv
`timescale 1ns/1ps
module dma_chan_csr_test;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [1:0] size = 2;
  logic [31:0] wdata = 0;
  logic ack, err;
  logic [31:0] rdata;
  logic [N-1:0] ev_be = 0, ev_st = 0, ev_en = 0, ev_sp = 0, ev_ra = 0, ev_eo = 0, dreq = 0;
  logic [N-1:0] run, fetch;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  dma_chan_csr #(.NUM_CH(N), .ADDR_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ack_o(ack), .err_o(err), .rdata_o(rdata),
    .ev_buserr_i(ev_be), .ev_start_i(ev_st), .ev_end_i(ev_en), .ev_stop_i(ev_sp),
    .ev_ras_i(ev_ra), .ev_eor_i(ev_eo), .dreq_i(dreq),
    .run_o(run), .fetch_o(fetch), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (q_data.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: unexpected ack, got 1 expected 0");
      end else begin
        string t;
        logic [31:0] d;
        logic e;
        d = q_data.pop_front(); e = q_err.pop_front(); t = q_tag.pop_front();
        chk(rdata, d, {t, " data"});
        chk(32'(err), 32'(e), {t, " err"});
      end
    end
  end

  // driver: starts and ends at a falling edge
  task automatic bus(input logic w, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic [31:0] exp, input logic exp_err,
                     input string tag);
    q_data.push_back(exp); q_err.push_back(exp_err); q_tag.push_back(tag);
    req = 1; we = w; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 0; we = 0; size = 2;
  endtask

  task automatic wr(input int ch, input logic [31:0] d, input string tag);
    bus(1'b1, 8'(ch * 4), 2'd2, d, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input int ch, input logic [31:0] exp, input string tag);
    bus(1'b0, 8'(ch * 4), 2'd2, 32'h0, exp, 1'b0, tag);
  endtask

  task automatic pulse(ref logic [N-1:0] ev, input int ch);
    ev[ch] = 1'b1;
    @(negedge clk);
    ev[ch] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(32'(run), 0, "R1 run");
    chk(32'(fetch), 0, "R1 fetch");
    chk(32'(irq), 0, "R1 irq");
    for (int c = 0; c < N; c++) rd(c, 32'h0000_0008, "R1 chan");
    bus(1'b0, 8'hF0, 2'd2, 0, 32'h0, 1'b0, "R1 summary");

    // R4 run in descriptor mode
    wr(0, 32'h8000_0000, "R4 wr0");
    chk(32'(fetch), 32'h1, "R4 fetch pulse");
    chk(32'(run), 32'h1, "R4 run");
    @(negedge clk);
    chk(32'(fetch), 0, "R4 fetch one cycle");
    rd(0, 32'h8000_0000, "R4 stop cleared");
    wr(1, 32'hC000_0000, "R4 wr1");
    chk(32'(fetch), 0, "R4 no fetch when nofetch");
    chk(32'(run), 32'h3, "R4 run1");
    rd(1, 32'hC000_0000, "R4 rd1");

    // R5 stop forcing and mask-run
    wr(1, 32'h0, "R5 wr1");
    rd(1, 32'h0000_0008, "R5 stop forced");
    wr(0, 32'h0040_0000, "R5 maskrun");
    rd(0, 32'h0, "R5 maskrun keeps stop R3 bit22");
    chk(32'(run), 0, "R5 run low");

    // R3 R6 full write
    wr(3, 32'hFFFF_FFFF, "R3 all ones");
    rd(3, 32'hFC80_0400, "R3 ctrl load R6 set wins");
    chk(32'(irq), 0, "R8 no flags");
    wr(3, 32'h4100_0000, "R6 clr");
    rd(3, 32'h4000_0008, "R6 cmp cleared");

    // R7 R8 R9 start event
    pulse(ev_st, 2);
    chk(32'(irq), 1, "R8 start unconditional");
    rd(2, 32'h0000_000A, "R7 start set");
    bus(1'b0, 8'hF0, 2'd2, 0, 32'h4, 1'b0, "R9 summary ch2");
    wr(2, 32'h0000_0002, "R2 clr start");
    chk(32'(irq), 0, "R2 irq after clear");
    rd(2, 32'h0000_0008, "R2 start cleared");

    // R8 bus error never interrupts
    pulse(ev_be, 2);
    chk(32'(irq), 0, "R8 buserr silent");
    rd(2, 32'h0000_0009, "R7 buserr set");
    wr(2, 32'h1, "R2 clr buserr");
    rd(2, 32'h0000_0008, "R2 buserr cleared");

    // R8 end of receive needs enable
    pulse(ev_eo, 1);
    chk(32'(irq), 0, "R8 eor no enable");
    wr(1, 32'h1000_0000, "R8 eorie");
    chk(32'(irq), 1, "R8 eor enabled");
    rd(1, 32'h1000_0208, "R2 eor kept");
    bus(1'b0, 8'hF0, 2'd2, 0, 32'h2, 1'b0, "R9 summary ch1");
    wr(1, 32'h1000_0200, "R2 clr eor");
    chk(32'(irq), 0, "R2 eor irq gone");
    rd(1, 32'h1000_0008, "R2 eor cleared");

    // R8 stopped needs enable
    wr(2, 32'h2000_0000, "R8 stopie");
    chk(32'(irq), 1, "R8 stop enabled");
    wr(2, 32'h0, "R8 stopie off");
    chk(32'(irq), 0, "R8 stop disabled");

    // R8 request after stop
    pulse(ev_ra, 0);
    chk(32'(irq), 0, "R8 ras no enable");
    wr(0, 32'h0080_0000, "R8 rasie");
    chk(32'(irq), 1, "R8 ras enabled");
    rd(0, 32'h0080_0018, "R3 rasie stored");
    wr(0, 32'h0, "R2 ras not w1c");
    rd(0, 32'h0000_0018, "R2 ras kept");

    // R7 event beats same-cycle clear
    pulse(ev_en, 0);
    chk(32'(irq), 1, "R8 end unconditional");
    ev_en[0] = 1'b1;
    wr(0, 32'h4, "R7 clr with event");
    ev_en[0] = 1'b0;
    rd(0, 32'h0000_001C, "R7 event wins");
    wr(0, 32'h4, "R2 clr end");
    rd(0, 32'h0000_0018, "R2 end cleared");
    chk(32'(irq), 0, "R9 irq low");

    // R7 engine stop
    wr(3, 32'h8000_0000, "R7 start ch3");
    chk(32'(run[3]), 1, "R7 run3");
    pulse(ev_sp, 3);
    chk(32'(run[3]), 0, "R7 stop clears run");
    rd(3, 32'h0000_0008, "R7 stop flag");

    // R10 live request level
    dreq[1] = 1'b1;
    rd(1, 32'h1000_0108, "R10 reqpend on");
    dreq[1] = 1'b0;
    rd(1, 32'h1000_0008, "R10 reqpend off");

    // R11 bad accesses
    bus(1'b1, 8'h08, 2'd0, 32'h8000_0000, 32'h0, 1'b1, "R11 byte write");
    chk(32'(run), 0, "R11 no run");
    chk(32'(fetch), 0, "R11 no fetch");
    rd(2, 32'h0000_0008, "R11 state kept");
    bus(1'b0, 8'h09, 2'd2, 0, 32'h0, 1'b1, "R11 misaligned read");

    repeat (2) @(negedge clk);
    chk(32'(q_data.size()), 0, "R12 all acks seen");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule